// File: doc/BRIEF.md
# Radix page table walker

This block turns an input virtual address into a real address by walking a tree of page directories held in memory. A walk begins at a root table, described by its base address, the number of index bits it consumes and the total width of the address space the tree covers. At each level a slice of the virtual address selects one 64-bit entry. The walker reads that entry through a single-request memory port. A directory entry gives the base and index width of the next level. A leaf entry ends the walk.

Before each level is read, the walker checks that the combination of level, remaining size and index width is one the tree format allows. When the walk completes it presents the leaf entry, the composed real address, the page-size exponent and the address the leaf was read from, together with a one-cycle done strobe. An invalid entry or an illegal level configuration ends the walk early with a fault flag. The walker keeps at most one memory read in flight, and a start request is taken only while the walker is idle.

Top module: `radix_walker`

## Requirements
- R1: A start request is taken only while `busy_o` is low. `busy_o` rises in the cycle after the accepting edge and stays high until the done cycle, inclusive. A start request while busy has no effect on the walk in progress or on its results.
- R2: The level configuration is checked before each read. Level 0 is legal only with remaining size 52 and index width 13. Levels 1 and 2 need index width 9. Level 3 accepts 9 or 5. Level 4 and deeper are illegal. An illegal level ends the walk with `fault_badcfg_o` and issues no read for that level.
- R3: At each level, index = (va >> (size − width)) masked to `width` bits. The entry address is the aligned base plus 8 × index.
- R4: A base that is not aligned to 2^(width+3) bytes is used with those low bits cleared, and the walk continues.
- R5: Entry bit 63 is the valid flag. A read entry with bit 63 clear ends the walk with `fault_nopte_o`.
- R6: After every valid read the remaining size drops by the current width. A directory entry (bit 62 clear) supplies the next width in bits [4:0] and the next base in bits [55:8], with base bits [7:0] taken as zero.
- R7: A leaf entry (bit 62 set) ends the walk. `raddr_o` takes the page-number bits [55:12] of the entry above bit position `size` and the virtual-address bits below it. `page_shift_o` is the remaining size. `leaf_o` is the entry and `leaf_addr_o` is the address it was read from.
- R8: `mem_req_o` is a one-cycle pulse, and no new request is issued until `mem_rvalid_i` returns the previous read.
- R9: `done_o` is high for exactly one cycle. At most one fault flag is set with it. All result outputs hold until the next accepted start.
- R10: `rst_ni` low returns the walker to idle at once, with no request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (taken when idle) |
| va_i | input | VA_W | Virtual address to translate |
| root_base_i | input | PA_W | Root table base address |
| root_nls_i | input | 5 | Root index width |
| size_i | input | 6 | Total address-space size exponent |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | PA_W | Read address, held until data returns |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_nopte_o | output | 1 | Walk hit an invalid entry |
| fault_badcfg_o | output | 1 | Walk hit an illegal level configuration |
| leaf_o | output | 64 | Leaf entry |
| raddr_o | output | PA_W | Translated real address |
| page_shift_o | output | 6 | Page-size exponent |
| leaf_addr_o | output | PA_W | Address of the leaf entry |

## Verification
The first request pulses in the cycle after the accepting edge, and each following level's request comes one cycle after the edge that samples `mem_rvalid_i`. `done_o` rises one cycle after the edge that samples the final data, or one cycle after the request cycle in which an illegal level is found. The bench drives inputs and samples outputs on falling edges. It waits for `done_o`, checks the results there, and checks one falling edge later that the strobe has dropped and the results hold. The bench's memory replies after one to three cycles, varying from read to read. The bench counts the requests of each walk and records the first request address, so the number of levels read and the index arithmetic are both checked against values derived from where the bench placed each entry.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;
  localparam int ENT_W     = 64;
  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;
  localparam int NLS_W     = 5;
  localparam int SHIFT_W   = 6;
  localparam int BASE_LSB  = 8;
  localparam int PAGE_LSB  = 12;
  localparam int ENT_BYTES_LOG2 = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic             valid;
    logic             leaf;
    logic [NLS_W-1:0] nls;
  } ent_hdr_t;

  function automatic ent_hdr_t decode_hdr(input logic [ENT_W-1:0] e);
    ent_hdr_t h;
    h.valid = e[VALID_BIT];
    h.leaf  = e[LEAF_BIT];
    h.nls   = e[NLS_W-1:0];
    return h;
  endfunction
endpackage

// File: rtl/radix_level_check.sv
module radix_level_check import radix_walk_pkg::*; #(
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = 3,
  parameter int ROOT_SIZE  = 52,
  parameter int ROOT_NLS   = 13,
  parameter int MID_NLS    = 9,
  parameter int ALT_NLS    = 5
) (
  input  logic [LVL_W-1:0]   lvl_i,
  input  logic [SHIFT_W-1:0] size_i,
  input  logic [NLS_W-1:0]   nls_i,
  output logic               legal_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(NUM_LEVELS - 1);

  always_comb begin
    legal_o = 1'b0;
    if (lvl_i == '0)
      legal_o = (size_i == SHIFT_W'(ROOT_SIZE)) && (nls_i == NLS_W'(ROOT_NLS));
    else if (lvl_i < LAST_LVL)
      legal_o = (nls_i == NLS_W'(MID_NLS));
    else if (lvl_i == LAST_LVL)
      legal_o = (nls_i == NLS_W'(MID_NLS)) || (nls_i == NLS_W'(ALT_NLS));
  end
endmodule

// File: rtl/radix_index_gen.sv
module radix_index_gen import radix_walk_pkg::*; #(
  parameter int VA_W = 64,
  parameter int PA_W = 56
) (
  input  logic [VA_W-1:0]    va_i,
  input  logic [PA_W-1:0]    base_i,
  input  logic [NLS_W-1:0]   nls_i,
  input  logic [SHIFT_W-1:0] size_i,
  output logic [PA_W-1:0]    ent_addr_o
);
  logic [SHIFT_W-1:0] shamt;
  logic [VA_W-1:0]    idx_mask;
  logic [VA_W-1:0]    idx;
  logic [PA_W-1:0]    align_mask;

  // size below width only happens on illegal levels, which never read
  assign shamt      = (size_i > SHIFT_W'(nls_i)) ? size_i - SHIFT_W'(nls_i) : '0;
  assign idx_mask   = ~({VA_W{1'b1}} << nls_i);
  assign idx        = (va_i >> shamt) & idx_mask;
  assign align_mask = {PA_W{1'b1}} << (nls_i + ENT_BYTES_LOG2);
  assign ent_addr_o = (base_i & align_mask) + (PA_W'(idx) << ENT_BYTES_LOG2);
endmodule

// File: rtl/radix_leaf_compose.sv
module radix_leaf_compose import radix_walk_pkg::*; #(
  parameter int PA_W = 56
) (
  input  logic [PA_W-1:0]    va_low_i,
  input  logic [PA_W-1:0]    ent_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [PA_W-1:0]    raddr_o
);
  logic [PA_W-1:0] page_num;
  logic [PA_W-1:0] low_mask;

  assign page_num = ent_i & ({PA_W{1'b1}} << PAGE_LSB);
  assign low_mask = ~({PA_W{1'b1}} << shift_i);
  assign raddr_o  = (page_num & ~low_mask) | (va_low_i & low_mask);
endmodule

// File: rtl/radix_walker.sv
module radix_walker import radix_walk_pkg::*; #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 56,
  parameter int NUM_LEVELS = 4,
  parameter int ROOT_SIZE  = 52,
  parameter int ROOT_NLS   = 13,
  parameter int MID_NLS    = 9,
  parameter int ALT_NLS    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [VA_W-1:0]    va_i,
  input  logic [PA_W-1:0]    root_base_i,
  input  logic [NLS_W-1:0]   root_nls_i,
  input  logic [SHIFT_W-1:0] size_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ENT_W-1:0]   mem_rdata_i,
  output logic               done_o,
  output logic               fault_nopte_o,
  output logic               fault_badcfg_o,
  output logic [ENT_W-1:0]   leaf_o,
  output logic [PA_W-1:0]    raddr_o,
  output logic [SHIFT_W-1:0] page_shift_o,
  output logic [PA_W-1:0]    leaf_addr_o
);
  localparam int LVL_W = $clog2(NUM_LEVELS + 1);

  walk_state_e        state_q;
  logic [VA_W-1:0]    va_q;
  logic [PA_W-1:0]    base_q;
  logic [NLS_W-1:0]   nls_q;
  logic [SHIFT_W-1:0] size_q;
  logic [LVL_W-1:0]   lvl_q;
  logic               nopte_q, badcfg_q;
  logic [ENT_W-1:0]   leaf_q;
  logic [PA_W-1:0]    raddr_q, leaf_addr_q;
  logic [SHIFT_W-1:0] shift_q;

  logic               legal;
  logic [PA_W-1:0]    ent_addr;
  logic [PA_W-1:0]    leaf_raddr;
  logic [SHIFT_W-1:0] size_next;
  ent_hdr_t           hdr;

  assign size_next = size_q - SHIFT_W'(nls_q);
  assign hdr       = decode_hdr(mem_rdata_i);

  radix_level_check #(
    .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .ROOT_SIZE(ROOT_SIZE),
    .ROOT_NLS(ROOT_NLS), .MID_NLS(MID_NLS), .ALT_NLS(ALT_NLS)
  ) u_level_check (
    .lvl_i   (lvl_q),
    .size_i  (size_q),
    .nls_i   (nls_q),
    .legal_o (legal)
  );

  radix_index_gen #(.VA_W(VA_W), .PA_W(PA_W)) u_index_gen (
    .va_i       (va_q),
    .base_i     (base_q),
    .nls_i      (nls_q),
    .size_i     (size_q),
    .ent_addr_o (ent_addr)
  );

  radix_leaf_compose #(.PA_W(PA_W)) u_leaf_compose (
    .va_low_i (va_q[PA_W-1:0]),
    .ent_i    (mem_rdata_i[PA_W-1:0]),
    .shift_i  (size_next),
    .raddr_o  (leaf_raddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      nls_q       <= '0;
      size_q      <= '0;
      lvl_q       <= '0;
      nopte_q     <= 1'b0;
      badcfg_q    <= 1'b0;
      leaf_q      <= '0;
      raddr_q     <= '0;
      leaf_addr_q <= '0;
      shift_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            va_q     <= va_i;
            base_q   <= root_base_i;
            nls_q    <= root_nls_i;
            size_q   <= size_i;
            lvl_q    <= '0;
            nopte_q  <= 1'b0;
            badcfg_q <= 1'b0;
            state_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!legal) begin
            badcfg_q <= 1'b1;
            state_q  <= ST_DONE;
          end else begin
            state_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            if (!hdr.valid) begin
              nopte_q <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              size_q <= size_next;
              if (hdr.leaf) begin
                leaf_q      <= mem_rdata_i;
                raddr_q     <= leaf_raddr;
                shift_q     <= size_next;
                leaf_addr_q <= ent_addr;
                state_q     <= ST_DONE;
              end else begin
                nls_q   <= hdr.nls;
                base_q  <= {mem_rdata_i[PA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
                lvl_q   <= lvl_q + 1'b1;
                state_q <= ST_ISSUE;
              end
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign mem_req_o      = (state_q == ST_ISSUE) && legal;
  assign mem_addr_o     = ent_addr;
  assign done_o         = (state_q == ST_DONE);
  assign fault_nopte_o  = nopte_q;
  assign fault_badcfg_o = badcfg_q;
  assign leaf_o         = leaf_q;
  assign raddr_o        = raddr_q;
  assign page_shift_o   = shift_q;
  assign leaf_addr_o    = leaf_addr_q;
endmodule

// File: rtl/radix_walker_checker.sv
module radix_walker_checker import radix_walk_pkg::*; #(
  parameter int PA_W       = 56,
  parameter int NUM_LEVELS = 4,
  parameter int ROOT_SIZE  = 52
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               mem_req_o,
  input logic [PA_W-1:0]    mem_addr_o,
  input logic               mem_rvalid_i,
  input logic               done_o,
  input logic               fault_nopte_o,
  input logic               fault_badcfg_o,
  input logic [SHIFT_W-1:0] page_shift_o
);
  localparam int CNT_W = $clog2(NUM_LEVELS + 2);

  logic             out_q;
  logic [CNT_W-1:0] rd_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= 1'b0;
      rd_cnt_q <= '0;
    end else begin
      if (mem_req_o) out_q <= 1'b1;
      else if (mem_rvalid_i) out_q <= 1'b0;
      if (start_i && !busy_o) rd_cnt_q <= '0;
      else if (mem_req_o && rd_cnt_q <= CNT_W'(NUM_LEVELS)) rd_cnt_q <= rd_cnt_q + 1'b1;
    end
  end

  a_r8_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !out_q);
  a_r8_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r3_entry_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[ENT_BYTES_LOG2-1:0] == '0));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_fault_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(fault_nopte_o && fault_badcfg_o));
  a_r1_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o));
  a_r2_read_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_q <= CNT_W'(NUM_LEVELS));
  a_r7_leaf_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_nopte_o && !fault_badcfg_o) |-> (page_shift_o < SHIFT_W'(ROOT_SIZE)));
endmodule

bind radix_walker radix_walker_checker #(
  .PA_W(PA_W), .NUM_LEVELS(NUM_LEVELS), .ROOT_SIZE(ROOT_SIZE)
) u_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .busy_o         (busy_o),
  .mem_req_o      (mem_req_o),
  .mem_addr_o     (mem_addr_o),
  .mem_rvalid_i   (mem_rvalid_i),
  .done_o         (done_o),
  .fault_nopte_o  (fault_nopte_o),
  .fault_badcfg_o (fault_badcfg_o),
  .page_shift_o   (page_shift_o)
);

// File: tb/radix_walker_test.sv
`timescale 1ns/1ps
module radix_walker_test;
  localparam int VA_W = 64;
  localparam int PA_W = 56;
  localparam logic [55:0] R0 = 56'h01_0000;
  localparam logic [55:0] L1 = 56'h04_0000;
  localparam logic [55:0] L2 = 56'h05_0000;
  localparam logic [55:0] L3 = 56'h06_0000;
  localparam logic [55:0] L4 = 56'h07_0000;
  localparam logic [55:0] PG = 56'hA5_C3E1_F00D_7000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [VA_W-1:0] va_i = '0;
  logic [PA_W-1:0] root_base_i = '0;
  logic [4:0] root_nls_i = '0;
  logic [5:0] size_i = '0;
  logic busy_o, mem_req_o, mem_rvalid_i, done_o, fault_nopte_o, fault_badcfg_o;
  logic [PA_W-1:0] mem_addr_o, raddr_o, leaf_addr_o;
  logic [63:0] mem_rdata_i, leaf_o;
  logic [5:0] page_shift_o;

  always #2 clk_i = ~clk_i;

  radix_walker uut (.*);

  logic [63:0] mem [logic [55:0]];
  logic [55:0] pend_addr, first_addr;
  int pend_cnt = 0;
  int nreq = 0;
  int run_base = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_cnt     <= 0;
      mem_rvalid_i <= 1'b0;
      mem_rdata_i  <= '0;
    end else begin
      mem_rvalid_i <= 1'b0;
      if (pend_cnt != 0) begin
        pend_cnt <= pend_cnt - 1;
        if (pend_cnt == 1) begin
          mem_rvalid_i <= 1'b1;
          mem_rdata_i  <= mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
        end
      end
      if (mem_req_o) begin
        pend_addr <= mem_addr_o;
        pend_cnt  <= 1 + (nreq % 3);
        if (nreq == run_base) first_addr <= mem_addr_o;
        nreq <= nreq + 1;
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dir_e(input logic [55:0] b, input logic [4:0] n);
    return {8'h80, b[55:8], 3'b000, n};
  endfunction
  function automatic logic [63:0] leaf_e(input logic [55:0] p);
    return {8'hC0, p[55:12], 12'h000};
  endfunction

  // expected: reads, outcome (0 ok,1 nopte,2 badcfg), shift
  int exp_reads, exp_kind, exp_shift;
  logic [55:0] exp_laddr, exp_first;

  task automatic build(input int sc, input logic [63:0] va, output logic [55:0] rbase,
                       output logic [4:0] rnls, output logic [5:0] rsize);
    logic [55:0] a0, a1, a2, a3, a3b;
    mem.delete();
    a0  = R0 + 56'(va[51:39]) * 8;
    a1  = L1 + 56'(va[38:30]) * 8;
    a2  = L2 + 56'(va[29:21]) * 8;
    a3  = L3 + 56'(va[20:12]) * 8;
    a3b = L3 + 56'(va[20:16]) * 8;
    rbase = R0; rnls = 5'd13; rsize = 6'd52;
    exp_first = a0;
    exp_kind = 0;
    case (sc)
      0: begin mem[a0]=dir_e(L1,9); mem[a1]=dir_e(L2,9); mem[a2]=dir_e(L3,9); mem[a3]=leaf_e(PG);
               exp_reads=4; exp_shift=12; exp_laddr=a3; end
      1: begin mem[a0]=dir_e(L1,9); mem[a1]=dir_e(L2,9); mem[a2]=dir_e(L3,5); mem[a3b]=leaf_e(PG);
               exp_reads=4; exp_shift=16; exp_laddr=a3b; end
      2: begin mem[a0]=dir_e(L1,9); mem[a1]=dir_e(L2,9); mem[a2]=leaf_e(PG);
               exp_reads=3; exp_shift=21; exp_laddr=a2; end
      3: begin mem[a0]=dir_e(L1,9); mem[a1]=leaf_e(PG); exp_reads=2; exp_shift=30; exp_laddr=a1; end
      4: begin mem[a0]=leaf_e(PG); exp_reads=1; exp_shift=39; exp_laddr=a0; end
      5: begin exp_reads=1; exp_kind=1; end
      6: begin mem[a0]=dir_e(L1,9); mem[a1]=dir_e(L2,9); exp_reads=3; exp_kind=1; end
      7: begin mem[a0]=dir_e(L1,10); exp_reads=1; exp_kind=2; end
      8: begin mem[a0]=dir_e(L1,9); mem[a1]=dir_e(L2,9); mem[a2]=dir_e(L3,7);
               exp_reads=3; exp_kind=2; end
      9: begin mem[a0]=dir_e(L1,9); mem[a1]=dir_e(L2,9); mem[a2]=dir_e(L3,9); mem[a3]=dir_e(L4,9);
               exp_reads=4; exp_kind=2; end
      10: begin mem[a0]=dir_e(L1,9); mem[a1]=dir_e(L2 + 56'h5A8,9); mem[a2]=dir_e(L3,9);
                mem[a3]=leaf_e(PG); exp_reads=4; exp_shift=12; exp_laddr=a3; end
      11: begin rnls = 5'd12; exp_reads=0; exp_kind=2; end
      12: begin rsize = 6'd48; exp_reads=0; exp_kind=2; end
      default: begin rbase = R0 + 56'h1238; mem[a0]=leaf_e(PG);
                exp_reads=1; exp_shift=39; exp_laddr=a0; end
    endcase
  endtask

  task automatic walk(input int sc, input logic [63:0] va, input bit interfere);
    logic [55:0] rb, mask, exp_ra;
    logic [4:0] rn;
    logic [5:0] rs;
    logic [63:0] s_leaf;
    logic [55:0] s_ra;
    int cyc;
    build(sc, va, rb, rn, rs);
    @(negedge clk_i);
    run_base = nreq;
    start_i = 1'b1; va_i = va; root_base_i = rb; root_nls_i = rn; size_i = rs;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R1 busy after start", busy_o, 1);
    if (interfere) begin
      @(negedge clk_i);
      start_i = 1'b1; va_i = ~va; size_i = 6'd48;
      @(negedge clk_i);
      start_i = 1'b0; va_i = va; size_i = rs;
    end
    cyc = 0;
    while (done_o !== 1'b1 && cyc < 400) begin @(negedge clk_i); cyc++; end
    chk("R9 done seen", done_o, 1);
    chk("R2 read count", nreq - run_base, exp_reads);
    if (exp_reads > 0) chk("R3/R4 first entry address", first_addr, exp_first);
    chk("R5 nopte flag", fault_nopte_o, exp_kind == 1);
    chk("R2 badcfg flag", fault_badcfg_o, exp_kind == 2);
    if (exp_kind == 0) begin
      mask   = (56'd1 << exp_shift) - 1;
      exp_ra = (PG & ~mask) | (va[55:0] & mask);
      chk("R7 raddr", raddr_o, exp_ra);
      chk("R7 page shift", page_shift_o, exp_shift);
      chk("R7 leaf entry", leaf_o, leaf_e(PG));
      chk("R6 leaf address", leaf_addr_o, exp_laddr);
      if (interfere) chk("R1 start while busy ignored", raddr_o, exp_ra);
    end
    s_leaf = leaf_o; s_ra = raddr_o;
    @(negedge clk_i);
    chk("R9 done one cycle", done_o, 0);
    chk("R9 result holds", {s_ra, s_leaf[7:0]}, {raddr_o, leaf_o[7:0]});
    chk("R1 idle after done", busy_o, 0);
  endtask

  initial begin
    logic [63:0] seed;
    seed = 64'h1234_5678_9ABC_DEF1;
    repeat (3) @(negedge clk_i);
    chk("R10 reset busy", busy_o, 0);
    chk("R10 reset req", mem_req_o, 0);
    chk("R10 reset done", done_o, 0);
    rst_ni = 1'b1;
    for (int sc = 0; sc < 14; sc++) begin
      for (int k = 0; k < 4; k++) begin
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        walk(sc, seed, (k == 1) && (sc == 0 || sc == 3 || sc == 10));
      end
    end
    // reset in mid-walk
    begin
      logic [55:0] rb; logic [4:0] rn; logic [5:0] rs;
      build(0, seed, rb, rn, rs);
      @(negedge clk_i);
      start_i = 1'b1; va_i = seed; root_base_i = rb; root_nls_i = rn; size_i = rs;
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b0;
      #1;
      chk("R10 mid-walk reset busy", busy_o, 0);
      chk("R10 mid-walk reset req", mem_req_o, 0);
      @(negedge clk_i);
      rst_ni = 1'b1;
      repeat (4) @(negedge clk_i);
      chk("R10 quiet after reset", done_o, 0);
    end
    walk(2, seed ^ 64'h0F0F_F0F0_1234_5678, 1'b0);
    finished = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end
endmodule